// File: doc/BRIEF.md
# Energy-efficient Ethernet low-power-idle controller

This block decides when the transmit side of an Ethernet MAC may signal Low-Power Idle (LPI) to the PHY, and when normal transmission may start again afterwards. A software request asks for LPI. The request is honoured only on a full-duplex link that has been up for a programmable number of milliseconds. Once LPI is dropped, transmission stays held off for a programmable number of microseconds so that the far end has time to wake.

Two saturating timers advance on single-cycle tick strobes from an external prescaler. The link-status holdoff timer is 10 bits wide and counts milliseconds. The wake timer is 16 bits wide and counts microseconds. Four sticky event bits record transmit LPI entry, transmit LPI exit, receive LPI entry and receive LPI exit. The interrupt output is the OR of these bits, and each bit is cleared by writing one to it.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: The holdoff timer is held at zero while `link_up_i` is low. While the link is up it advances by one on each cycle with `ms_tick_i` high and on no other cycle, so after a link drop the full holdoff must elapse again.
- R2: The holdoff timer saturates at `ls_limit_i` and does not wrap. With a limit of 1023 and more than 1024 ticks since link-up, a request still enters LPI.
- R3: `lpi_assert_o` rises only at a clock edge at which the link is up, full duplex is set, `lpi_req_i` is high, and the holdoff count has already reached `ls_limit_i`. It rises at the edge after the cycle in which all of these hold.
- R4: Leaving LPI by dropping the request (or duplex) moves to a wake phase at the next edge. In the wake phase `lpi_assert_o` and `tx_resume_o` are both low, and the wake timer starts from zero and advances only on `us_tick_i`.
- R5: `tx_resume_o` is high in the active state and low during LPI and wake. It returns high at the edge after the first cycle in which the wake count is at least `tw_limit_i`. A limit of 0 gives exactly one wake cycle.
- R6: A request that is raised during the wake phase does not re-enter LPI until the wake phase has completed.
- R7: The status bits `status_o` are bit 0 for transmit entry, bit 1 for transmit exit, bit 2 for receive entry (rising `rx_lpi_i`) and bit 3 for receive exit (falling `rx_lpi_i`). Each is set at the edge at which its event takes effect, and `irq_o` is high whenever any bit is set.
- R8: A one in bit i of `sts_clr_i` clears status bit i at the next edge. An event that occurs in the same cycle wins over the clear.
- R9: While `full_duplex_i` is low, requests are ignored: no LPI entry and no entry event. Dropping duplex during LPI starts the wake phase.
- R10: When the link drops, `lpi_assert_o` falls in the same cycle. The controller then returns to the active state at the next edge and both timers reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| link_up_i | input | 1 | Link status, high when the link is up |
| full_duplex_i | input | 1 | High when the link runs full duplex |
| lpi_req_i | input | 1 | Software request for transmit LPI |
| rx_lpi_i | input | 1 | Receive side is in LPI |
| ms_tick_i | input | 1 | One-cycle millisecond strobe |
| us_tick_i | input | 1 | One-cycle microsecond strobe |
| ls_limit_i | input | 10 | Holdoff terminal count in ms |
| tw_limit_i | input | 16 | Wake terminal count in µs |
| sts_clr_i | input | 4 | Write-one-to-clear strobes for the status bits |
| lpi_assert_o | output | 1 | LPI signal toward the PHY |
| tx_resume_o | output | 1 | Normal transmission allowed |
| status_o | output | 4 | Sticky event bits |
| irq_o | output | 1 | OR of the status bits |

## Verification
Assertions check the timer rules on every cycle: clearing, advancing only on a tick, and saturation. They also check that LPI is entered only from a satisfied holdoff with duplex and a request present, that the active state is reached only from a finished wake or a link drop, that LPI never survives a link drop, and that an event always raises the interrupt. Other behaviour shows up only in bench scenarios. These are the end-to-end latency in tick counts, the absence of wrap after more than 1024 ticks, the blocking of a request raised during wake, the one-cycle wake with a zero limit, and the priority of set over clear. The bench covers them with directed sequences and with a long random run checked against a cycle model.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;
  typedef enum logic [1:0] {
    TX_ACTIVE = 2'd0,
    TX_LPI    = 2'd1,
    TX_WAKE   = 2'd2
  } tx_state_e;

  localparam int unsigned EVT_W        = 4;
  localparam int unsigned EVT_TX_ENTER = 0;
  localparam int unsigned EVT_TX_EXIT  = 1;
  localparam int unsigned EVT_RX_ENTER = 2;
  localparam int unsigned EVT_RX_EXIT  = 3;
endpackage

// File: rtl/lpi_tick_timer.sv
module lpi_tick_timer #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_limit;

  assign at_limit = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (tick_i && !at_limit)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = at_limit;

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R1
  AST_TICK_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick_i) |=> $stable(cnt_q)); // R1
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && at_limit) |=> (cnt_q == $past(cnt_q))); // R2
endmodule

// File: rtl/lpi_tx_fsm.sv
module lpi_tx_fsm
  import eee_lpi_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      link_up_i,
  input  logic      fdx_i,
  input  logic      req_i,
  input  logic      ls_done_i,
  input  logic      tw_done_i,
  output tx_state_e state_o,
  output logic      enter_o,
  output logic      exit_o
);
  tx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TX_ACTIVE: if (link_up_i && fdx_i && req_i && ls_done_i) state_d = TX_LPI;
      TX_LPI: begin
        if (!link_up_i)          state_d = TX_ACTIVE;
        else if (!req_i || !fdx_i) state_d = TX_WAKE;
      end
      TX_WAKE: begin
        if (!link_up_i)    state_d = TX_ACTIVE;
        else if (tw_done_i) state_d = TX_ACTIVE;
      end
      default: state_d = TX_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TX_ACTIVE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign enter_o = (state_d == TX_LPI) && (state_q != TX_LPI);
  assign exit_o  = (state_q == TX_LPI) && (state_d != TX_LPI);

  AST_ENTRY_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_LPI && $past(state_q) != TX_LPI) |-> $past(ls_done_i && fdx_i && req_i && link_up_i)); // R3
  AST_RESUME_AFTER_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_ACTIVE && $past(state_q) == TX_WAKE) |-> $past(tw_done_i || !link_up_i)); // R5
  AST_NO_REENTRY_FROM_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_WAKE) |=> (state_q != TX_LPI)); // R6
  AST_HALF_DUPLEX_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_ACTIVE && !fdx_i) |=> (state_q != TX_LPI)); // R9
  AST_LINK_DROP_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_up_i |=> (state_q == TX_ACTIVE)); // R10
endmodule

// File: rtl/lpi_event_status.sv
module lpi_event_status #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o,
  output logic         irq_o
);
  logic [N-1:0] sts_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sts_q[i] <= 1'b0;
      else if (set_i[i]) sts_q[i] <= 1'b1;
      else if (clr_i[i]) sts_q[i] <= 1'b0;
    end

    AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !sts_q[i]); // R8
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> sts_q[i]); // R8
  end

  assign sts_o = sts_q;
  assign irq_o = |sts_q;

  AST_EVENT_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> irq_o); // R7
endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
  import eee_lpi_pkg::*;
#(
  parameter int unsigned LS_W = 10,
  parameter int unsigned TW_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             link_up_i,
  input  logic             full_duplex_i,
  input  logic             lpi_req_i,
  input  logic             rx_lpi_i,
  input  logic             ms_tick_i,
  input  logic             us_tick_i,
  input  logic [LS_W-1:0]  ls_limit_i,
  input  logic [TW_W-1:0]  tw_limit_i,
  input  logic [EVT_W-1:0] sts_clr_i,
  output logic             lpi_assert_o,
  output logic             tx_resume_o,
  output logic [EVT_W-1:0] status_o,
  output logic             irq_o
);
  tx_state_e        state;
  logic             ls_cnt_done, tw_cnt_done, ls_done;
  logic             tx_enter, tx_exit;
  logic             rx_q;
  logic [EVT_W-1:0] evt;

  lpi_tick_timer #(.CNT_W(LS_W)) u_ls_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!link_up_i),
    .tick_i  (ms_tick_i),
    .limit_i (ls_limit_i),
    .done_o  (ls_cnt_done)
  );

  // wake count is held at zero outside the wake phase
  lpi_tick_timer #(.CNT_W(TW_W)) u_tw_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!link_up_i || state != TX_WAKE),
    .tick_i  (us_tick_i),
    .limit_i (tw_limit_i),
    .done_o  (tw_cnt_done)
  );

  assign ls_done = link_up_i && ls_cnt_done;

  lpi_tx_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .link_up_i (link_up_i),
    .fdx_i     (full_duplex_i),
    .req_i     (lpi_req_i),
    .ls_done_i (ls_done),
    .tw_done_i (tw_cnt_done),
    .state_o   (state),
    .enter_o   (tx_enter),
    .exit_o    (tx_exit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 1'b0;
    else         rx_q <= rx_lpi_i;
  end

  always_comb begin
    evt               = '0;
    evt[EVT_TX_ENTER] = tx_enter;
    evt[EVT_TX_EXIT]  = tx_exit;
    evt[EVT_RX_ENTER] = rx_lpi_i && !rx_q;
    evt[EVT_RX_EXIT]  = !rx_lpi_i && rx_q;
  end

  lpi_event_status #(.N(EVT_W)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt),
    .clr_i  (sts_clr_i),
    .sts_o  (status_o),
    .irq_o  (irq_o)
  );

  // link loss drops LPI without waiting for the state register
  assign lpi_assert_o = (state == TX_LPI) && link_up_i;
  assign tx_resume_o  = (state == TX_ACTIVE);

  AST_LPI_NOT_WHILE_RESUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lpi_assert_o && tx_resume_o)); // R5
  AST_LPI_NEEDS_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lpi_assert_o |-> $past(link_up_i)); // R10
endmodule

// File: tb/eee_lpi_ctrl_tb.sv
`timescale 1ns/1ps
module eee_lpi_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link = 1'b0, fdx = 1'b1, req = 1'b0, rx = 1'b0, mst = 1'b0, ust = 1'b0;
  logic [9:0]  lsl = 10'd0;
  logic [15:0] twl = 16'd0;
  logic [3:0]  clr = 4'd0;
  logic        lpi_o, resume_o, irq_o;
  logic [3:0]  sts_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state: 0 active, 1 lpi, 2 wake
  int          m_st = 0, m_ls = 0, m_tw = 0;
  logic        m_rxq = 1'b0;
  logic [3:0]  m_sts = 4'd0;

  always #2.5 clk = ~clk;

  eee_lpi_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .link_up_i(link), .full_duplex_i(fdx),
    .lpi_req_i(req), .rx_lpi_i(rx), .ms_tick_i(mst), .us_tick_i(ust),
    .ls_limit_i(lsl), .tw_limit_i(twl), .sts_clr_i(clr),
    .lpi_assert_o(lpi_o), .tx_resume_o(resume_o), .status_o(sts_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_lpi();   return (m_st == 1 && link) ? 1 : 0; endfunction
  function automatic int exp_res();   return (m_st == 0) ? 1 : 0; endfunction

  task automatic model_step();
    int nst, nls, ntw;
    logic [3:0] set;
    bit lsd;
    lsd = link && (m_ls >= lsl);
    nst = m_st;
    case (m_st)
      0: if (link && fdx && req && lsd) nst = 1;
      1: if (!link) nst = 0; else if (!req || !fdx) nst = 2;
      default: if (!link) nst = 0; else if (m_tw >= twl) nst = 0;
    endcase
    nls = !link ? 0 : ((mst && m_ls < lsl) ? m_ls + 1 : m_ls);
    ntw = (!link || m_st != 2) ? 0 : ((ust && m_tw < twl) ? m_tw + 1 : m_tw);
    set[0] = (nst == 1) && (m_st != 1);
    set[1] = (m_st == 1) && (nst != 1);
    set[2] = rx && !m_rxq;
    set[3] = !rx && m_rxq;
    m_sts = (m_sts & ~clr) | set;
    m_st = nst; m_ls = nls; m_tw = ntw; m_rxq = rx;
  endtask

  // one clock: model updates at the edge, outputs compared at the falling edge
  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(lpi_o == exp_lpi(),    "R3 lpi_assert model", lpi_o, exp_lpi());
    chk(resume_o == exp_res(), "R5 tx_resume model",  resume_o, exp_res());
    chk(sts_o == m_sts,        "R7 status model",     sts_o, m_sts);
    chk(irq_o == (|m_sts),     "R8 irq model",        irq_o, |m_sts);
  endtask

  task automatic ms_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      mst = 1'b1; cycle(); mst = 1'b0; cycle();
    end
  endtask

  task automatic us_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ust = 1'b1; cycle(); ust = 1'b0; cycle();
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1a7e));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(lpi_o == 0 && resume_o == 1, "R3 reset outputs", {lpi_o, resume_o}, 1);
    chk(sts_o == 0 && irq_o == 0, "R8 reset status", sts_o, 0);

    // holdoff gating
    lsl = 10'd5; twl = 16'd3; link = 1'b1; fdx = 1'b1; req = 1'b1;
    cycle();
    ms_ticks(4);
    chk(lpi_o == 0, "R3 held before holdoff", lpi_o, 0);
    ms_ticks(1); cycle();
    chk(lpi_o == 1, "R3 enter after holdoff", lpi_o, 1);
    chk(sts_o[0] == 1, "R7 tx entry bit", sts_o[0], 1);

    // link drop
    link = 1'b0; #1;
    chk(lpi_o == 0, "R10 same-cycle deassert", lpi_o, 0);
    cycle();
    chk(resume_o == 1, "R10 back to active", resume_o, 1);
    link = 1'b1;
    ms_ticks(4);
    chk(lpi_o == 0, "R1 holdoff restarted", lpi_o, 0);
    ms_ticks(1); cycle();
    chk(lpi_o == 1, "R1 enter after fresh holdoff", lpi_o, 1);

    // wake phase
    req = 1'b0; cycle();
    chk(lpi_o == 0 && resume_o == 0, "R4 wake entered", {lpi_o, resume_o}, 0);
    us_ticks(2);
    chk(resume_o == 0, "R5 still waking", resume_o, 0);
    req = 1'b1;
    chk(lpi_o == 0, "R6 request during wake", lpi_o, 0);
    us_ticks(1);
    chk(resume_o == 1 && lpi_o == 0, "R5 resume after wake", {lpi_o, resume_o}, 1);
    cycle();
    chk(lpi_o == 1, "R6 reentry after wake", lpi_o, 1);

    // saturation with max holdoff
    twl = 16'd0; req = 1'b0; cycle();
    chk(resume_o == 0, "R5 zero-limit wake cycle", resume_o, 0);
    cycle();
    chk(resume_o == 1, "R5 zero-limit one cycle", resume_o, 1);
    lsl = 10'd1023; link = 1'b0; cycle(); link = 1'b1;
    mst = 1'b1;
    for (int i = 0; i < 1100; i++) cycle();
    mst = 1'b0; req = 1'b1; cycle(); cycle();
    chk(lpi_o == 1, "R2 no wrap past 1024 ticks", lpi_o, 1);

    // half duplex
    req = 1'b0; cycle(); cycle(); cycle();
    clr = 4'hF; cycle(); clr = 4'h0;
    fdx = 1'b0; req = 1'b1;
    for (int i = 0; i < 20; i++) cycle();
    chk(lpi_o == 0 && sts_o[0] == 0, "R9 half duplex ignored", {lpi_o, sts_o[0]}, 0);
    fdx = 1'b1; cycle(); cycle();
    chk(lpi_o == 1, "R9 full duplex enters", lpi_o, 1);
    fdx = 1'b0; cycle();
    chk(lpi_o == 0 && resume_o == 0, "R9 duplex drop wakes", {lpi_o, resume_o}, 0);
    cycle(); cycle();

    // status and clear
    clr = 4'hF; cycle(); clr = 4'h0;
    chk(irq_o == 0, "R8 cleared irq", irq_o, 0);
    rx = 1'b1; cycle();
    chk(sts_o == 4'b0100 && irq_o, "R7 rx entry bit", sts_o, 4);
    rx = 1'b0; cycle();
    chk(sts_o == 4'b1100, "R7 rx exit bit", sts_o, 12);
    clr = 4'b0100; cycle(); clr = 4'h0;
    chk(sts_o == 4'b1000, "R8 single clear", sts_o, 8);
    rx = 1'b1; clr = 4'b0100; cycle(); clr = 4'h0;
    chk(sts_o[2] == 1, "R8 set wins over clear", sts_o[2], 1);

    // random phase
    fdx = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 199) == 0) lsl = 10'($urandom_range(0, 6));
      if ($urandom_range(0, 199) == 0) twl = 16'($urandom_range(0, 6));
      if ($urandom_range(0, 79) == 0)  link = ~link;
      if ($urandom_range(0, 15) == 0)  req = ~req;
      if ($urandom_range(0, 63) == 0)  fdx = ~fdx;
      if ($urandom_range(0, 19) == 0)  rx = ~rx;
      mst = ($urandom_range(0, 2) == 0);
      ust = ($urandom_range(0, 2) == 0);
      clr = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
      cycle();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule